// File: doc/BRIEF.md
# Synchronous Single-Port SRAM with Selectable Read Pipeline

This block is a synthesizable single-port synchronous SRAM. Chip select, address, write data and the write strobes are all captured in input registers on the rising clock edge. The captured command then writes the array or reads it. A new command can be accepted on every cycle without a stall.

Writes are controlled per byte. The word is split into 9-bit lanes. A lane is written only when the byte-write enable and that lane's strobe are both set. A global write stores the whole word no matter what the lane strobes say.

Two static mode inputs set the read side. The first picks flow-through or pipelined read latency. The second picks how long the output drive stays on after a deselect. The output presents data together with a drive-enable flag, in the manner of a three-state bus. An asynchronous output enable gates that flag.

Top module: `ssram_core`

## Requirements
- R1: While reset is held and on the first cycle after it, `drive_en` is 0 and `rdata` is all zeros.
- R2: With `pipe_mode`=0 (flow-through), a read captured at edge k drives the addressed word on `rdata` in the cycle that follows edge k.
- R3: With `pipe_mode`=1 (pipelined), a read captured at edge k drives the addressed word on `rdata` in the cycle that follows edge k+1.
- R4: With `pipe_mode`=1 and `dual_desel`=0, a deselect (`ce`=0) captured at edge j turns `drive_en` off in the cycle after edge j.
- R5: With `pipe_mode`=1 and `dual_desel`=1, a deselect captured at edge j leaves the preceding read's word driven through the cycle after edge j. The drive turns off only after edge j+1.
- R6: With `pipe_mode`=0, `drive_en` follows the captured read under either deselect setting. A deselect or write captured at edge j turns it off after edge j.
- R7: A command with `ce`=1, `bw_en`=1 and `gw`=0 writes only the lanes whose `byte_sel` bit is 1. Lane i is bits [9i+8:9i]. The other lanes keep their contents.
- R8: A command with `ce`=1 and `gw`=1 writes all lanes, whatever the values of `bw_en` and `byte_sel`.
- R9: A cycle with `ce`=0 writes nothing, even when `gw` or `bw_en` is set.
- R10: A read of an address in the cycle right after a write to that address returns the newly written data.
- R11: When `oe` is 0, `drive_en` is 0 at once, without waiting for a clock edge. Whenever `drive_en` is 0, `rdata` is all zeros.
- R12: Reads to changing addresses, issued back to back on every cycle, each return their own word at the latency the mode sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip select; 0 captures a deselect |
| addr | input | ADDR_W | Word address |
| byte_sel | input | WORD_W/9 | Per-lane write strobes |
| bw_en | input | 1 | Byte-write enable |
| gw | input | 1 | Global write, all lanes |
| wdata | input | WORD_W | Write data |
| oe | input | 1 | Asynchronous output enable |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through |
| dual_desel | input | 1 | 1 = two-stage deselect, 0 = one-stage |
| rdata | output | WORD_W | Read data, zero when not driven |
| drive_en | output | 1 | Output drive enable |

## Verification
The bench builds the block with its defaults: a 36-bit word in four 9-bit lanes and 64 words of depth. This lets it preload every address and then revisit each one many times during the random phase. Random traffic mixes reads, lane-masked writes, global writes, deselects carrying stray write strobes, output-enable changes and switches of both mode inputs. This brings all four latency and deselect combinations into reach, along with write-then-read pairs on a single address.

// File: rtl/ssram_pkg.sv
// Package: shared command encoding and lane constants for the SRAM model.
// Assumes: lanes are 9 bits wide; the word width is a multiple of the lane width.
package ssram_pkg;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } ssram_op_e;
endpackage

// File: rtl/ssram_capture.sv
// Module: input register stage. Samples select, address, data and write
// strobes on the rising edge. Decodes them into one command and a lane mask.
// Assumes: synchronous active-low reset; all strobes are active-high.
module ssram_capture
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 36,
    parameter int NLANE  = WORD_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLANE-1:0]  byte_sel,
    input  logic              bw_en,
    input  logic              gw,
    input  logic [WORD_W-1:0] wdata,
    output ssram_op_e         op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [NLANE-1:0]  mask_q,
    output logic [WORD_W-1:0] wdata_q
);
    ssram_op_e        op_d;
    logic [NLANE-1:0] mask_d;

    // Decode the incoming strobes into a command and the lanes it writes.
    always_comb begin
        op_d   = OP_IDLE;
        mask_d = '0;
        if (ce) begin
            op_d = (gw || bw_en) ? OP_WRITE : OP_READ;
            if (gw)
                mask_d = '1;
            else if (bw_en)
                mask_d = byte_sel;
        end
    end

    // Capture the decoded command and its operands on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            addr_q  <= '0;
            mask_q  <= '0;
            wdata_q <= '0;
        end else begin
            op_q    <= op_d;
            addr_q  <= addr;
            mask_q  <= mask_d;
            wdata_q <= wdata;
        end
    end

    AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && gw) |=> (op_q == OP_WRITE && mask_q == {NLANE{1'b1}})); // R8

    AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> (op_q == OP_IDLE && mask_q == '0)); // R9
endmodule

// File: rtl/ssram_array.sv
// Module: storage array with per-lane write enables. The write uses the
// registered command at the next edge. The read is combinational from the
// registered address.
// Assumes: contents are not reset; one command per cycle (read or write).
module ssram_array
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 36,
    parameter int NLANE  = WORD_W / LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [NLANE-1:0]  mask_q,
    input  logic [WORD_W-1:0] wdata_q,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        // Write this lane when the registered command selects it.
        always_ff @(posedge clk) begin
            if (wr_en && mask_q[g])
                mem[addr_q][g*LANE_W +: LANE_W] <= wdata_q[g*LANE_W +: LANE_W];
        end
    end

    // Flow-through read path from the registered address.
    always_comb rd_word = mem[addr_q];

    AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(wr_en) && $past(mask_q) == {NLANE{1'b1}}
         && addr_q == $past(addr_q)) |-> (rd_word == $past(wdata_q))); // R10
endmodule

// File: rtl/ssram_outstage.sv
// Module: output stage. Holds the pipeline data register and the read-flag
// register. Selects flow-through or pipelined data. Applies the deselect
// policy and the asynchronous output enable to the drive flag.
// Assumes: mode inputs are static while traffic is in flight.
module ssram_outstage
    import ssram_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              dual_desel,
    input  logic              oe,
    input  ssram_op_e         op_q,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] rdata,
    output logic              drive_en
);
    logic              rd_stage2;
    logic [WORD_W-1:0] dout_q;
    logic              sel_core;
    logic [WORD_W-1:0] data_sel;

    // Second read stage: flag and data register loaded by a captured read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stage2 <= 1'b0;
            dout_q    <= '0;
        end else begin
            rd_stage2 <= (op_q == OP_READ);
            if (op_q == OP_READ)
                dout_q <= rd_word;
        end
    end

    // Deselect policy: single-stage cuts the drive as soon as a deselect is captured.
    always_comb begin
        if (!pipe_mode)
            sel_core = (op_q == OP_READ);
        else if (dual_desel)
            sel_core = rd_stage2;
        else
            sel_core = rd_stage2 && (op_q != OP_IDLE);
    end

    // Gate by the asynchronous enable and park the data bus when not driving.
    always_comb begin
        data_sel = pipe_mode ? dout_q : rd_word;
        drive_en = oe && sel_core;
        rdata    = drive_en ? data_sel : '0;
    end

    AST_SCD_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !dual_desel && op_q == OP_IDLE) |-> !drive_en); // R4

    AST_DCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && dual_desel && oe && $past(op_q == OP_READ)) |-> drive_en); // R5

    AST_FT_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && op_q != OP_READ) |-> !drive_en); // R6
endmodule

// File: rtl/ssram_core.sv
// Module: top of the synchronous SRAM. It chains the input capture, the array
// and the output stage, so reads take one cycle (flow-through) or two
// (pipelined) after the command is presented.
// Assumes: synchronous active-low reset; WORD_W is a multiple of 9.
module ssram_core
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 36,
    localparam int NLANE = WORD_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLANE-1:0]  byte_sel,
    input  logic              bw_en,
    input  logic              gw,
    input  logic [WORD_W-1:0] wdata,
    input  logic              oe,
    input  logic              pipe_mode,
    input  logic              dual_desel,
    output logic [WORD_W-1:0] rdata,
    output logic              drive_en
);
    ssram_op_e         op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NLANE-1:0]  mask_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rd_word;

    ssram_capture #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NLANE(NLANE)) i_capture (
        .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .byte_sel(byte_sel),
        .bw_en(bw_en), .gw(gw), .wdata(wdata),
        .op_q(op_q), .addr_q(addr_q), .mask_q(mask_q), .wdata_q(wdata_q)
    );

    ssram_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NLANE(NLANE)) i_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(op_q == OP_WRITE), .rd_en(op_q == OP_READ),
        .addr_q(addr_q), .mask_q(mask_q), .wdata_q(wdata_q), .rd_word(rd_word)
    );

    ssram_outstage #(.WORD_W(WORD_W)) i_outstage (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .dual_desel(dual_desel),
        .oe(oe), .op_q(op_q), .rd_word(rd_word), .rdata(rdata), .drive_en(drive_en)
    );
endmodule

// File: tb/test_ssram_core.sv
`timescale 1ns/100ps
module test_ssram_core;
    localparam int AW = 6;
    localparam int W  = 36;
    localparam int NB = W / 9;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce, bw_en, gw, oe, pipe_mode, dual_desel;
    logic [AW-1:0] addr;
    logic [NB-1:0] byte_sel;
    logic [W-1:0]  wdata;
    logic [W-1:0]  rdata;
    logic          drive_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state, advanced from the requirements at each edge.
    logic [W-1:0]  m_mem [DEPTH];
    logic          c_ce, c_rd, c_wr, p_rd;
    logic [AW-1:0] c_addr;
    logic [NB-1:0] c_mask;
    logic [W-1:0]  c_data, p_dout;

    always #2.5 clk = ~clk;

    ssram_core #(.ADDR_W(AW), .WORD_W(W)) i_ssram_core (
        .clk(clk), .rst_n(rst_n), .ce(ce), .addr(addr), .byte_sel(byte_sel),
        .bw_en(bw_en), .gw(gw), .wdata(wdata), .oe(oe), .pipe_mode(pipe_mode),
        .dual_desel(dual_desel), .rdata(rdata), .drive_en(drive_en)
    );

    function automatic logic [NB-1:0] lane_mask(logic g, logic b, logic [NB-1:0] s);
        return g ? {NB{1'b1}} : (b ? s : '0);
    endfunction

    function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw, logic [NB-1:0] m);
        logic [W-1:0] r = old;
        for (int i = 0; i < NB; i++)
            if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    function automatic logic exp_drive();
        logic s;
        if (!pipe_mode) s = c_rd;
        else if (dual_desel) s = p_rd;
        else s = p_rd && c_ce;
        return oe && s;
    endfunction

    function automatic logic [W-1:0] exp_data();
        if (!exp_drive()) return '0;
        return pipe_mode ? p_dout : m_mem[c_addr];
    endfunction

    task automatic check(string tag);
        logic          ed = exp_drive();
        logic [W-1:0]  ev = exp_data();
        checks++;
        if (drive_en !== ed || rdata !== ev) begin
            failures++;
            $display("FAIL %s: drive_en=%0b rdata=%h expected drive_en=%0b rdata=%h",
                     tag, drive_en, rdata, ed, ev);
        end
    endtask

    // One cycle: drive at the falling edge, advance the model at the rising edge, check at the next falling edge.
    task automatic step(logic c, logic [AW-1:0] a, logic g, logic b,
                        logic [NB-1:0] s, logic [W-1:0] d, string tag);
        ce = c; addr = a; gw = g; bw_en = b; byte_sel = s; wdata = d;
        @(posedge clk);
        if (c_wr) m_mem[c_addr] = merge(m_mem[c_addr], c_data, c_mask);
        if (c_rd) p_dout = m_mem[c_addr];
        p_rd   = c_rd;
        c_ce   = c;
        c_rd   = c && !g && !b;
        c_wr   = c && (g || b);
        c_addr = a;
        c_mask = c ? lane_mask(g, b, s) : '0;
        c_data = d;
        @(negedge clk);
        check(tag);
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        step(1'b1, a, 1'b0, 1'b0, '0, '0, tag);
    endtask

    task automatic idle(string tag);
        step(1'b0, '0, 1'b0, 1'b0, '0, '0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pat;
        void'($urandom(32'd2024));
        rst_n = 1'b0; ce = 0; addr = '0; gw = 0; bw_en = 0; byte_sel = '0; wdata = '0;
        oe = 1'b1; pipe_mode = 1'b1; dual_desel = 1'b0;
        c_ce = 0; c_rd = 0; c_wr = 0; p_rd = 0; c_addr = '0; c_mask = '0; c_data = '0; p_dout = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        idle("R1 after reset");

        // Preload every word with global writes; byte strobes set to noise (R8).
        for (int i = 0; i < DEPTH; i++) begin
            pat = {4'h5, 32'($urandom)} ^ W'(i);
            step(1'b1, AW'(i), 1'b1, i[0], NB'(i), pat, "R8 preload");
        end

        // Flow-through reads, then deselect cut-off under both policies (R2, R6).
        pipe_mode = 1'b0; dual_desel = 1'b0;
        rd(6'd3, "R2 flow-through read");
        rd(6'd4, "R2 flow-through next");
        idle("R6 ft deselect single");
        dual_desel = 1'b1;
        rd(6'd9, "R2 flow-through read");
        idle("R6 ft deselect dual");

        // Pipelined latency and single-stage deselect (R3, R4).
        pipe_mode = 1'b1; dual_desel = 1'b0;
        rd(6'd10, "R3 pipe read issue");
        rd(6'd11, "R3 pipe data 10");
        idle("R4 scd cut at deselect");
        idle("R4 scd stays off");

        // Dual-stage deselect keeps the last word for one more cycle (R5).
        dual_desel = 1'b1;
        rd(6'd12, "R5 pipe read issue");
        rd(6'd13, "R5 pipe data 12");
        idle("R5 dcd holds data 13");
        idle("R5 dcd off");

        // Masked lane write, then read back in flow-through (R7).
        pipe_mode = 1'b0;
        step(1'b1, 6'd20, 1'b0, 1'b1, 4'b0101, 36'hABCDE1234, "R7 lane write");
        rd(6'd20, "R7 masked readback");
        step(1'b1, 6'd21, 1'b0, 1'b1, 4'b0000, 36'hFFFFFFFFF, "R7 empty mask write");
        rd(6'd21, "R7 no lanes changed");

        // Deselected cycle with write strobes changes nothing (R9).
        step(1'b0, 6'd22, 1'b1, 1'b1, 4'b1111, 36'h0DEADBEEF, "R9 deselect with gw");
        rd(6'd22, "R9 word unchanged");

        // Write then read same address on the next cycle, both modes (R10).
        step(1'b1, 6'd30, 1'b1, 1'b0, '0, 36'h123456789, "R10 write");
        rd(6'd30, "R10 ft read after write");
        pipe_mode = 1'b1;
        step(1'b1, 6'd31, 1'b1, 1'b0, '0, 36'h987654321, "R10 write");
        rd(6'd31, "R10 pipe read issue");
        idle("R10 pipe data");

        // Output enable acts without a clock edge (R11).
        pipe_mode = 1'b0;
        rd(6'd5, "R11 driven read");
        oe = 1'b0; #1; check("R11 oe low async");
        oe = 1'b1; #1; check("R11 oe high async");

        // Back-to-back reads, each address differs (R12).
        pipe_mode = 1'b1; dual_desel = 1'b0;
        for (int i = 0; i < 8; i++) rd(AW'(40 + i), "R12 pipe stream");
        pipe_mode = 1'b0;
        for (int i = 0; i < 8; i++) rd(AW'(50 + i), "R12 ft stream");

        // Constrained random mix of every command and mode.
        for (int n = 0; n < 1500; n++) begin
            int k = $urandom_range(0, 9);
            if ($urandom_range(0, 31) == 0) pipe_mode = ~pipe_mode;
            if ($urandom_range(0, 31) == 0) dual_desel = ~dual_desel;
            oe = ($urandom_range(0, 7) != 0);
            if (k < 5)
                rd(AW'($urandom), "R12 random read");
            else if (k < 7)
                step(1'b1, AW'($urandom), 1'b0, 1'b1, NB'($urandom), {4'($urandom), 32'($urandom)}, "R7 random lane write");
            else if (k < 8)
                step(1'b1, AW'($urandom), 1'b1, 1'($urandom), NB'($urandom), {4'($urandom), 32'($urandom)}, "R8 random global write");
            else
                step(1'b0, AW'($urandom), 1'($urandom), 1'($urandom), NB'($urandom), {4'($urandom), 32'($urandom)}, "R9 random deselect");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule